// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder (16-bit)

This block adds two 16-bit unsigned operands and a carry-in and produces a 16-bit sum and a carry-out. It has no clock, state or reset. The operand is split into four 4-bit slices. Each slice forms per-bit generate (a AND b) and propagate (a XOR b) terms and computes its own internal carries as flattened sums of products, so no carry inside a slice waits on the carry below it. Each slice also reports a group generate and a group propagate.

A second lookahead level takes the four group terms and the carry-in and produces the carries into bits 4, 8 and 12 and the final carry-out. Each of these is computed directly from the group terms and the carry-in, not by chaining one group carry into the next. No gate in either level sees more than four product terms from its own level plus the incoming carry. The block-level generate and propagate are also brought out, so several of these adders can sit under a third lookahead level.

Top module: `cla16_two_level`

## Requirements
- R1: For every input, {cout, sum} equals a + b + cin taken as a 17-bit unsigned sum.
- R2: With cin = 0 and all inputs zero, sum and cout are all zero and blk_p and blk_g are 0.
- R3: The carry into bit 4k, for k = 1, 2, 3, observed as sum[4k] XOR a[4k] XOR b[4k], equals bit 4k of the sum of the low 4k bits of a and b and cin.
- R4: blk_p is 1 exactly when a XOR b is all ones, meaning every bit propagates.
- R5: blk_g is 1 exactly when a + b with no carry-in reaches 2^16.
- R6: cout equals blk_g OR (blk_p AND cin).
- R7: When a XOR b is all ones, cin = 1 gives sum = 0 and cout = 1, and cin = 0 gives sum = 16'hFFFF and cout = 0. The carry-in passes through all sixteen bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| blk_p | output | 1 | Block propagate: every bit propagates |
| blk_g | output | 1 | Block generate: the block produces a carry on its own |

## Verification
Random operand pairs under both carry-in values exercise the general sum. Operand pairs that propagate through every bit, with a XOR b all ones, show whether a carry-in reaches the top through both lookahead levels, and they separate blk_p from blk_g. Alternating bit patterns and slice-boundary cases, such as 16'h000F + 1 or 16'h0FFF + 1, force a carry that is generated in one slice and must cross into the next. A wrong group term or a wrong second-level product shows up in the recovered carry at bit 4, 8 or 12. Maximum operands with cin = 1 test the case where every bit both generates and receives a carry.

// File: rtl/cla16_two_level.sv
`timescale 1ns/1ps
module cla16_two_level #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         blk_p,
  output logic         blk_g
);
  localparam int NS = W / SW;

  logic [W-1:0]  p, g, c;
  logic [NS-1:0] gp, gg;
  logic [NS:0]   gc;

  assign p = a ^ b;
  assign g = a & b;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    localparam int B = k * SW;
    assign c[B]   = gc[k];
    assign c[B+1] = g[B] | (p[B] & gc[k]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & gc[k]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B])
                  | (p[B+2] & p[B+1] & p[B] & gc[k]);
    assign gp[k]  = &p[B +: SW];
    assign gg[k]  = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1])
                  | (p[B+3] & p[B+2] & p[B+1] & g[B]);
  end

  assign gc[0] = cin;
  assign gc[1] = gg[0] | (gp[0] & cin);
  assign gc[2] = gg[1] | (gp[1] & gg[0]) | (gp[1] & gp[0] & cin);
  assign gc[3] = gg[2] | (gp[2] & gg[1]) | (gp[2] & gp[1] & gg[0])
               | (gp[2] & gp[1] & gp[0] & cin);

  assign blk_p = &gp;
  assign blk_g = gg[3] | (gp[3] & gg[2]) | (gp[3] & gp[2] & gg[1])
               | (gp[3] & gp[2] & gp[1] & gg[0]);
  assign gc[4] = blk_g | (blk_p & cin);

  assign sum  = p ^ c;
  assign cout = gc[NS];

  always_comb begin
    logic [W:0] ref_full, ref_nocin, mask, part;
    ref_full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    ref_nocin = {1'b0, a} + {1'b0, b};
    p_sum_r1: assert ({cout, sum} == ref_full)
      else $error("R1 sum mismatch");
    for (int k = 1; k < NS; k++) begin
      mask = ({{W{1'b0}}, 1'b1} << (k * SW)) - 1'b1;
      part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{W{1'b0}}, cin};
      p_slice_carry_r3: assert (gc[k] == part[k*SW])
        else $error("R3 slice carry mismatch");
    end
    p_blk_prop_r4: assert (blk_p == (&(a ^ b)))
      else $error("R4 block propagate mismatch");
    p_blk_gen_r5: assert (blk_g == ref_nocin[W])
      else $error("R5 block generate mismatch");
    p_cout_r6: assert (cout == (ref_nocin[W] | ((&(a ^ b)) & cin)))
      else $error("R6 carry-out relation mismatch");
  end
endmodule

// File: tb/cla16_two_level_bench.sv
`timescale 1ns/1ps
module cla16_two_level_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] a, b, sum;
  logic cin, cout, blk_p, blk_g;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  cla16_two_level u_cla16_two_level (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .blk_p(blk_p), .blk_g(blk_g)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] xa, input logic [15:0] xb, input logic xc);
    longint full, nocin, part, act_full;
    @(posedge clk);
    a = xa; b = xb; cin = xc;
    @(negedge clk);
    full  = longint'(xa) + longint'(xb) + longint'(xc);
    nocin = longint'(xa) + longint'(xb);
    act_full = {cout, sum};
    chk(act_full == full, "R1", act_full, full);
    for (int k = 1; k < 4; k++) begin
      part = (longint'(xa) & ((64'd1 << (4*k)) - 1)) + (longint'(xb) & ((64'd1 << (4*k)) - 1)) + longint'(xc);
      chk((sum[4*k] ^ xa[4*k] ^ xb[4*k]) == part[4*k], "R3",
          longint'(sum[4*k] ^ xa[4*k] ^ xb[4*k]), longint'(part[4*k]));
    end
    chk(blk_p == ((xa ^ xb) == 16'hFFFF), "R4", longint'(blk_p), longint'((xa ^ xb) == 16'hFFFF));
    chk(blk_g == nocin[16], "R5", longint'(blk_g), longint'(nocin[16]));
    chk(cout == (blk_g | (blk_p & xc)), "R6", longint'(cout), longint'(blk_g | (blk_p & xc)));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    apply(16'h0000, 16'h0000, 1'b0);
    chk({cout, sum, blk_p, blk_g} == 19'd0, "R2", longint'({cout, sum, blk_p, blk_g}), 0);
    // R7: carry-in crosses all sixteen bits
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk(sum == 16'h0000 && cout, "R7", longint'({cout, sum}), 64'h10000);
    apply(16'hAAAA, 16'h5555, 1'b1);
    chk(sum == 16'h0000 && cout, "R7", longint'({cout, sum}), 64'h10000);
    apply(16'hAAAA, 16'h5555, 1'b0);
    chk(sum == 16'hFFFF && !cout, "R7", longint'({cout, sum}), 64'h0FFFF);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'hFFFF, 16'h0001, 1'b0);
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h00FF, 16'h0000, 1'b1);
    apply(16'h0FFF, 16'h0001, 1'b0);
    apply(16'h0F0F, 16'h00F1, 1'b0);
    apply(16'hAAAA, 16'hAAAA, 1'b1);
    apply(16'h5555, 16'h5555, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0);
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule